// File: doc/BRIEF.md
# Pipelined Asynchronous SRAM Controller

This block sits between an on-chip bus master and an external asynchronous static RAM. It assumes a 100 MHz clock and a RAM with 15 ns access time, so every RAM access takes two clock cycles. The master issues single-cycle read or write commands. The controller tells the master how many cycles remain through a two-bit ready counter. A value of 0 means that read data is available or that the last write has finished.

Every signal that leaves toward the RAM comes from a flip-flop, so it can be placed in an I/O-pad register. This covers the address, the write data, the data-bus drive enable, chip select and output enable. Read data is captured in an input register. The write strobe comes from a flip-flop clocked on the falling edge, which lets a write finish within two cycles. A new command is taken while the ready counter shows 0 or 1. Two reads therefore overlap at pipeline level 2, and no extra address or data register is needed. Each read result stays on the output until a newer read result replaces it.

Top module: `sram_pipe_ctrl`

## Requirements
- R1: After reset, ready count is 0, chip select, output enable and write strobe are high (inactive), the data-bus drive enable is low, and read data is 0.
- R2: A read taken in cycle N drives the address, with chip select and output enable low, in cycles N+1 and N+2. The ready count reads 2, 1 and 0 in cycles N+1, N+2 and N+3. From cycle N+3 the read data equals the RAM word at that address.
- R3: A command is accepted only while the ready count is 0 or 1. A second read issued in cycle N+2 returns its data in cycle N+5. The first result stays valid in cycles N+3 and N+4, while the ready count shows 2 and then 1.
- R4: Read data holds its value until a newer read completes, and writes leave it unchanged. With no command, a ready count of 0 stays 0.
- R5: A write taken in cycle N drives the address, the write data, drive enable high and chip select low in cycles N+1 and N+2, with the ready count at 2, 1, then 0 in N+3. The active-low write strobe falls at the falling edge inside N+1 and rises at the falling edge inside N+2.
- R6: The drive enable is low from cycle N+3 unless another write follows. The drive enable is never high while output enable is low, including a read issued right behind a write.
- R7: A command presented while the ready count is 2 is ignored. It changes neither the RAM pins nor the RAM contents.
- R8: When read and write are requested in the same cycle, only the write is performed.
- R9: Both pipeline-level outputs read the constant 2.
- R10: A write issued in cycle N+2 behind a write in cycle N stores both words.
- R11: The RAM address stays stable across both cycles of every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write strobe register uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr | input | AW | Word address, valid with a command |
| cmd_wdata | input | DW | Write data, valid with a write command |
| cmd_rd | input | 1 | Single-cycle read request |
| cmd_wr | input | 1 | Single-cycle write request |
| rsp_rdata | output | DW | Registered read result, held until the next result |
| rsp_rdy_cnt | output | 2 | Cycles remaining until the current access finishes |
| rd_pipe_lvl | output | 2 | Static read pipeline level (2) |
| wr_pipe_lvl | output | 2 | Static write pipeline level (2) |
| ram_addr | output | AW | Registered RAM address pins |
| ram_dout | output | DW | Registered RAM write data |
| ram_dout_en | output | 1 | Registered drive enable for the RAM data bus |
| ram_din | input | DW | RAM data bus as seen by the input register |
| ram_ncs | output | 1 | Registered active-low chip select |
| ram_noe | output | 1 | Registered active-low output enable |
| ram_nwe | output | 1 | Active-low write strobe from a falling-edge flip-flop |

## Verification
The assertions assume the RAM returns a stable word on its data bus before the rising edge that closes the second cycle of a read. They also assume that a master respects the ready count, but R7 checks that a command at count 2 is dropped rather than trusted. The bench's behavioural RAM presents data combinationally while chip select and output enable are low, and it stores on the rising write strobe. This meets the first assumption with room to spare. The stimulus issues reads and writes at the earliest legal slot and at idle gaps, and it deliberately places a few commands at count 2 or sets read and write together, so those paths are seen at the ports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int          RC_W       = 2;
  localparam logic [1:0]  RC_LOAD    = 2'd2;
  localparam logic [1:0]  PIPE_LEVEL = 2'd2;

  // next value of the ready counter: loaded on an accepted command,
  // otherwise counting down to zero and resting there
  function automatic logic [RC_W-1:0] rc_next(input logic [RC_W-1:0] cur,
                                              input logic load);
    if (load)              return RC_LOAD;
    else if (cur == '0)    return '0;
    else                   return cur - 1'b1;
  endfunction

  // a command may start when at most one cycle of the current access remains
  function automatic logic rc_open(input logic [RC_W-1:0] cur);
    return cur < RC_LOAD;
  endfunction

endpackage

// File: rtl/sram_cmd_track.sv
module sram_cmd_track
  import sram_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic            wr,
  output logic [RC_W-1:0] rdy_cnt,
  output logic            acc_rd,
  output logic            acc_wr,
  output logic            rd_s1,
  output logic            rd_s2,
  output logic            wr_s1
);

  logic open_slot;

  assign open_slot = rc_open(rdy_cnt);
  assign acc_wr    = wr & open_slot;
  assign acc_rd    = rd & ~wr & open_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_cnt <= '0;
      rd_s1   <= 1'b0;
      rd_s2   <= 1'b0;
      wr_s1   <= 1'b0;
    end else begin
      rdy_cnt <= rc_next(rdy_cnt, acc_rd | acc_wr);
      rd_s1   <= acc_rd;
      rd_s2   <= rd_s1;
      wr_s1   <= acc_wr;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd2) |=> (rdy_cnt == 2'd1)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd0 && !rd && !wr) |=> (rdy_cnt == 2'd0)); // R4
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_rd, acc_wr})); // R8
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd2) |-> !(acc_rd || acc_wr)); // R7

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs #(
  parameter int AW = 18,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic          rd_s1,
  input  logic          wr_s1,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dout,
  output logic          ram_dout_en,
  output logic          ram_ncs,
  output logic          ram_noe,
  output logic          ram_nwe
);

  logic sel_next, oe_next, drv_next;

  assign sel_next = acc_rd | acc_wr | rd_s1 | wr_s1;
  assign oe_next  = acc_rd | rd_s1;
  assign drv_next = acc_wr | wr_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr    <= '0;
      ram_dout    <= '0;
      ram_dout_en <= 1'b0;
      ram_ncs     <= 1'b1;
      ram_noe     <= 1'b1;
    end else begin
      if (acc_rd | acc_wr) ram_addr <= addr;
      if (acc_wr)          ram_dout <= wdata;
      ram_dout_en <= drv_next;
      ram_ncs     <= ~sel_next;
      ram_noe     <= ~oe_next;
    end
  end

  // falling-edge strobe: low from mid first write cycle to mid second
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ram_nwe <= 1'b1;
    else        ram_nwe <= ~wr_s1;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dout_en && !ram_noe)); // R6
  AST_NWE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_nwe |-> (!ram_ncs && ram_dout_en)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s1 || wr_s1) |=> $stable(ram_addr)); // R11

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= din;
  end

endmodule

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          cmd_rd,
  input  logic          cmd_wr,
  output logic [DW-1:0] rsp_rdata,
  output logic [1:0]    rsp_rdy_cnt,
  output logic [1:0]    rd_pipe_lvl,
  output logic [1:0]    wr_pipe_lvl,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dout,
  output logic          ram_dout_en,
  input  logic [DW-1:0] ram_din,
  output logic          ram_ncs,
  output logic          ram_noe,
  output logic          ram_nwe
);

  // named internal events, visible to assertions
  logic acc_rd, acc_wr, rd_s1, rd_s2, wr_s1;

  assign rd_pipe_lvl = PIPE_LEVEL;
  assign wr_pipe_lvl = PIPE_LEVEL;

  sram_cmd_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (cmd_rd),
    .wr      (cmd_wr),
    .rdy_cnt (rsp_rdy_cnt),
    .acc_rd  (acc_rd),
    .acc_wr  (acc_wr),
    .rd_s1   (rd_s1),
    .rd_s2   (rd_s2),
    .wr_s1   (wr_s1)
  );

  sram_pin_regs #(.AW(AW), .DW(DW)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .rd_s1       (rd_s1),
    .wr_s1       (wr_s1),
    .addr        (cmd_addr),
    .wdata       (cmd_wdata),
    .ram_addr    (ram_addr),
    .ram_dout    (ram_dout),
    .ram_dout_en (ram_dout_en),
    .ram_ncs     (ram_ncs),
    .ram_noe     (ram_noe),
    .ram_nwe     (ram_nwe)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (rd_s2),
    .din   (ram_din),
    .q     (rsp_rdata)
  );

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> (rsp_rdy_cnt != 2'd1)); // R4
  AST_BUSY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rdy_cnt == 2'd2) |=> ($stable(ram_addr) && $stable(ram_dout))); // R7
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s2 |-> (!ram_ncs && !ram_noe && ram_nwe)); // R2
  AST_LEVEL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pipe_lvl == 2'd2) && (wr_pipe_lvl == 2'd2)); // R9

endmodule

// File: tb/tb_sram_pipe_ctrl.sv
module tb_sram_pipe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_rd = 1'b0, cmd_wr = 1'b0;
  logic [DW-1:0] rsp_rdata, ram_dout, ram_din;
  logic [1:0] rsp_rdy_cnt, rd_pipe_lvl, wr_pipe_lvl;
  logic [AW-1:0] ram_addr;
  logic ram_dout_en, ram_ncs, ram_noe, ram_nwe;

  logic [DW-1:0] mem [NW];
  logic [DW-1:0] exp_mem [NW];
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_pipe_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .rsp_rdata(rsp_rdata),
    .rsp_rdy_cnt(rsp_rdy_cnt), .rd_pipe_lvl(rd_pipe_lvl),
    .wr_pipe_lvl(wr_pipe_lvl), .ram_addr(ram_addr), .ram_dout(ram_dout),
    .ram_dout_en(ram_dout_en), .ram_din(ram_din), .ram_ncs(ram_ncs),
    .ram_noe(ram_noe), .ram_nwe(ram_nwe)
  );

  // behavioural asynchronous RAM
  assign ram_din = (!ram_ncs && !ram_noe) ? mem[ram_addr] : '0;
  always @(posedge ram_nwe)
    if (!ram_ncs && ram_dout_en) mem[ram_addr] <= ram_dout;

  function automatic logic [DW-1:0] pat(input int i, input int k);
    return DW'((i * 16'h1357) ^ (k * 16'h0bad) ^ 16'h5a3c);
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // drive one cycle of command, leave at 1 time unit after the closing edge
  task automatic tick(input logic r, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_rd = r; cmd_wr = w; cmd_addr = a; cmd_wdata = d;
    @(posedge clk); #1;
    cmd_rd = 1'b0; cmd_wr = 1'b0;
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    for (int i = 0; i < NW; i++) begin
      mem[i] = pat(i, 0);
      exp_mem[i] = pat(i, 0);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R9 reset state
    chk(rsp_rdy_cnt == 0, "R1 rdy_cnt", 32'(rsp_rdy_cnt), 0);
    chk(ram_ncs && ram_noe && ram_nwe, "R1 strobes", {ram_ncs, ram_noe, ram_nwe}, 3'b111);
    chk(!ram_dout_en, "R1 dout_en", 32'(ram_dout_en), 0);
    chk(rsp_rdata == 0, "R1 rdata", 32'(rsp_rdata), 0);
    chk(rd_pipe_lvl == 2 && wr_pipe_lvl == 2, "R9 levels",
        {rd_pipe_lvl, wr_pipe_lvl}, 4'b1010);

    // R2 / R4 / R11 single reads over every address
    for (int a = 0; a < NW; a++) begin
      tick(1'b1, 1'b0, AW'(a), '0);                       // now N+1
      chk(ram_addr == AW'(a) && !ram_ncs && !ram_noe, "R2 pins N+1", 32'(ram_addr), 32'(a));
      chk(rsp_rdy_cnt == 2, "R2 cnt N+1", 32'(rsp_rdy_cnt), 2);
      idle();                                              // N+2
      chk(rsp_rdy_cnt == 1, "R2 cnt N+2", 32'(rsp_rdy_cnt), 1);
      chk(ram_addr == AW'(a) && !ram_noe, "R11 addr N+2", 32'(ram_addr), 32'(a));
      idle();                                              // N+3
      chk(rsp_rdy_cnt == 0, "R2 cnt N+3", 32'(rsp_rdy_cnt), 0);
      chk(rsp_rdata == exp_mem[a], "R2 rdata", 32'(rsp_rdata), 32'(exp_mem[a]));
      chk(ram_ncs && ram_noe, "R2 release", {ram_ncs, ram_noe}, 2'b11);
      idle(); idle();
      chk(rsp_rdy_cnt == 0 && rsp_rdata == exp_mem[a], "R4 idle hold",
          32'(rsp_rdata), 32'(exp_mem[a]));
    end

    // R5 / R6 / R4 writes over every address with strobe timing
    held = rsp_rdata;
    for (int a = 0; a < NW; a++) begin
      tick(1'b0, 1'b1, AW'(a), pat(a, 1));                  // N+1 (+1)
      chk(ram_dout_en && ram_dout == pat(a, 1) && ram_addr == AW'(a) && !ram_ncs && ram_noe,
          "R5 pins N+1", 32'(ram_dout), 32'(pat(a, 1)));
      chk(ram_nwe && rsp_rdy_cnt == 2, "R5 nwe early N+1", 32'(ram_nwe), 1);
      #5;
      chk(!ram_nwe, "R5 nwe low mid N+1", 32'(ram_nwe), 0);
      #5;                                                   // N+2 (+1)
      chk(!ram_nwe && ram_dout_en && rsp_rdy_cnt == 1, "R5 N+2",
          {ram_nwe, ram_dout_en, rsp_rdy_cnt}, 4'b0101);
      #5;
      chk(ram_nwe, "R5 nwe high mid N+2", 32'(ram_nwe), 1);
      #5;                                                   // N+3 (+1)
      chk(!ram_dout_en && ram_ncs && rsp_rdy_cnt == 0, "R6 bus released",
          {ram_dout_en, ram_ncs, rsp_rdy_cnt}, 4'b0100);
      chk(rsp_rdata == held, "R4 write keeps rdata", 32'(rsp_rdata), 32'(held));
      exp_mem[a] = pat(a, 1);
    end

    // R3 pipelined reads every address, reverse order
    for (int i = 0; i < NW; i++) begin
      tick(1'b1, 1'b0, AW'(NW - 1 - i), '0);
      if (i > 0) begin
        chk(rsp_rdy_cnt == 2 && rsp_rdata == exp_mem[NW - i], "R3 result at cnt 2",
            32'(rsp_rdata), 32'(exp_mem[NW - i]));
      end
      idle();
      if (i > 0) begin
        chk(rsp_rdy_cnt == 1 && rsp_rdata == exp_mem[NW - i], "R3 result at cnt 1",
            32'(rsp_rdata), 32'(exp_mem[NW - i]));
      end
    end
    idle();
    chk(rsp_rdy_cnt == 0 && rsp_rdata == exp_mem[0], "R3 last result",
        32'(rsp_rdata), 32'(exp_mem[0]));

    // R10 back-to-back writes at level 2
    for (int a = 0; a < NW; a += 2) begin
      tick(1'b0, 1'b1, AW'(a), pat(a, 2));
      idle();
      tick(1'b0, 1'b1, AW'(a + 1), pat(a + 1, 2));
      chk(ram_dout_en && ram_addr == AW'(a + 1), "R10 second write pins",
          32'(ram_addr), 32'(a + 1));
      idle(); idle();
      exp_mem[a] = pat(a, 2);
      exp_mem[a + 1] = pat(a + 1, 2);
    end
    for (int a = 0; a < NW; a++) begin
      tick(1'b1, 1'b0, AW'(a), '0); idle(); idle();
      chk(rsp_rdata == exp_mem[a], "R10 readback", 32'(rsp_rdata), 32'(exp_mem[a]));
    end

    // R7 write while count is 2 is dropped
    tick(1'b1, 1'b0, AW'(3), '0);                            // N+1, cnt 2
    tick(1'b0, 1'b1, AW'(9), 16'hdead);                      // N+2
    chk(!ram_dout_en && ram_addr == AW'(3) && rsp_rdy_cnt == 1, "R7 pins unchanged",
        32'(ram_addr), 3);
    idle();
    chk(rsp_rdata == exp_mem[3], "R7 first read intact", 32'(rsp_rdata), 32'(exp_mem[3]));
    idle();
    tick(1'b1, 1'b0, AW'(9), '0); idle(); idle();
    chk(rsp_rdata == exp_mem[9], "R7 ram unchanged", 32'(rsp_rdata), 32'(exp_mem[9]));

    // R8 read and write together: write wins
    held = rsp_rdata;
    tick(1'b1, 1'b1, AW'(5), 16'hbeef);
    chk(ram_dout_en && ram_noe, "R8 write taken", {ram_dout_en, ram_noe}, 2'b11);
    idle(); idle();
    chk(rsp_rdata == held, "R8 no read", 32'(rsp_rdata), 32'(held));
    exp_mem[5] = 16'hbeef;

    // R6 read right behind a write at level 2
    tick(1'b0, 1'b1, AW'(6), 16'h1234);
    idle();
    tick(1'b1, 1'b0, AW'(6), '0);                            // N+3 of write
    chk(!ram_dout_en && !ram_noe, "R6 handover", {ram_dout_en, ram_noe}, 2'b00);
    idle(); idle();
    chk(rsp_rdata == 16'h1234, "R6 read after write", 32'(rsp_rdata), 32'h1234);
    tick(1'b1, 1'b0, AW'(5), '0); idle(); idle();
    chk(rsp_rdata == 16'hbeef, "R8 write stored", 32'(rsp_rdata), 32'hbeef);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule